// File: doc/BRIEF.md
# Flash Rewrite Mode Control Register

This block is the control and status register that lets a processor put its on-chip flash into a self-reprogramming mode and take it out again. It sits on a simple register bus with a write strobe, an address, write data and combinational read data. Two bits are protected. The mode-select bit and the flash-reset bit change only through fixed pairs of consecutive register writes, so stray software cannot enter rewrite mode or reset the array.

Alongside the register the block tracks several conditions. It reports rewrite-mode entry. It checks the main-clock divider setting against the limit for the current wait-state setting. It raises a sticky warning when rewrite mode is left without first restoring the array to read mode. After a system reset it presents the boot execute start address. If that reset cut into an erase, it first holds a not-ready output for a recovery time that is fixed by parameters. The flash array, the command decoder, the clock divider and the CPU are outside the block and appear only as status inputs.

Top module: `flash_rw_ctrl`

## Requirements
- R1: Rewrite mode (CTRL at address 0, bit 0) turns on only when an accepted CTRL write with bit 0 = 0 is followed, as the very next accepted write, by a CTRL write with bit 0 = 1. A lone write of 1 leaves the mode off.
- R2: A single accepted CTRL write with bit 0 = 0 turns rewrite mode off.
- R3: An accepted CTRL write with bit 1 = 1, followed as the next accepted write by a CTRL write with bit 1 = 0, drives `flash_rst_o` high for exactly the one cycle after that second write.
- R4: Any accepted write that is not the matching second step, to any address including STATUS (address 1), cancels a pending sequence. The sequence must then restart from its first write.
- R5: `rw_active_o` and STATUS bit 0 report the current rewrite mode. A read of CTRL returns bit 0 = mode and bit 1 = 0. STATUS bits are: 0 active, 1 config error, 2 warning, 3 ready.
- R6: If `erase_busy_i` was high in the last cycle before `rst_ni` fell, `ready_o` stays low for HOLD_CYC+1 cycles after reset release, where HOLD_CYC = CLK_KHZ*HOLD_US/1000. Otherwise it stays low for 1 cycle. Writes are ignored while `ready_o` is low.
- R7: `boot_addr_o` equals BOOT_ADDR (default 0x07E000).
- R8: `cfg_err_o` is high exactly when rewrite mode is on and SRC_KHZ >> `clk_div_i` exceeds 5000 kHz (`wait_i` = 0) or 10000 kHz (`wait_i` = 1).
- R9: `warn_o` is set, and stays set until reset, when rewrite mode is turned off while an `op_start_i` has been seen with no `read_array_i` or flash-reset pulse after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| erase_busy_i | input | 1 | Flash erase in progress |
| op_start_i | input | 1 | Erase or program operation started |
| read_array_i | input | 1 | Read-array command issued |
| wait_i | input | 1 | Internal access wait state enabled |
| clk_div_i | input | DIV_W | Main clock divide code (divide by 2^code) |
| rw_active_o | output | 1 | Rewrite mode entry flag |
| flash_rst_o | output | 1 | One-cycle flash reset pulse |
| cfg_err_o | output | 1 | Clock setting illegal in rewrite mode |
| warn_o | output | 1 | Sticky unsafe-exit warning |
| ready_o | output | 1 | Reset recovery complete |
| boot_addr_o | output | 24 | Boot execute start address |

## Verification
The bench builds the block with CLK_KHZ = 1000 and HOLD_US = 50, so the recovery hold is 50 cycles and the exact hold length, and writes arriving during the hold, can be measured cycle by cycle. SRC_KHZ stays at 20000. At that value the four divide codes give 20000, 10000, 5000 and 2500 kHz, which puts one code exactly on each wait-state limit. The configuration-error boundary is therefore hit from both sides.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int NPROT     = 2;
  // bit 0 = mode select (arms on 0), bit 1 = flash reset (arms on 1)
  localparam logic [NPROT-1:0] FIRST_VAL = 2'b10;
  localparam int B_MODE = 0;
  localparam int B_FRST = 1;
  localparam int S_ACT  = 0;
  localparam int S_ERR  = 1;
  localparam int S_WARN = 2;
  localparam int S_RDY  = 3;
endpackage

// File: rtl/frc_unlock.sv
module frc_unlock #(
  parameter logic FIRST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic hit_i,
  input  logic bit_i,
  output logic fire_o
);
  logic arm_q;

  assign fire_o = wr_i && hit_i && arm_q && (bit_i == !FIRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   arm_q <= 1'b0;
    else if (wr_i) arm_q <= hit_i && (bit_i == FIRST);
  end
endmodule

// File: rtl/frc_hold.sv
module frc_hold #(
  parameter int CLK_KHZ = 10000,
  parameter int HOLD_US = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic erase_busy_i,
  output logic ready_o
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_US / 1000;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);

  logic             cut_q;
  logic             init_q;
  logic [CNT_W-1:0] cnt_q;

  // frozen while reset is low: remembers erase state at reset entry
  always_ff @(posedge clk_i) begin
    if (rst_ni) cut_q <= erase_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      cnt_q  <= '0;
    end else if (init_q) begin
      init_q <= 1'b0;
      cnt_q  <= cut_q ? CNT_W'(HOLD_CYC) : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = !init_q && (cnt_q == '0);
endmodule

// File: rtl/frc_clkchk.sv
module frc_clkchk #(
  parameter int SRC_KHZ    = 20000,
  parameter int LIM0_KHZ   = 5000,
  parameter int LIM1_KHZ   = 10000,
  parameter int DIV_W      = 2
) (
  input  logic             active_i,
  input  logic             wait_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic             err_o
);
  logic [31:0] freq;
  logic [31:0] lim;

  always_comb begin
    freq  = 32'(SRC_KHZ) >> clk_div_i;
    lim   = wait_i ? 32'(LIM1_KHZ) : 32'(LIM0_KHZ);
    err_o = active_i && (freq > lim);
  end
endmodule

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
  import frc_pkg::*;
#(
  parameter int          ADDR_W    = 2,
  parameter int          DATA_W    = 8,
  parameter int          DIV_W     = 2,
  parameter int          CLK_KHZ   = 10000,
  parameter int          HOLD_US   = 5000,
  parameter int          SRC_KHZ   = 20000,
  parameter int          LIM0_KHZ  = 5000,
  parameter int          LIM1_KHZ  = 10000,
  parameter logic [23:0] BOOT_ADDR = 24'h07E000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              erase_busy_i,
  input  logic              op_start_i,
  input  logic              read_array_i,
  input  logic              wait_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  output logic              rw_active_o,
  output logic              flash_rst_o,
  output logic              cfg_err_o,
  output logic              warn_o,
  output logic              ready_o,
  output logic [23:0]       boot_addr_o
);
  logic             acc;
  logic             ctrl_hit;
  logic [NPROT-1:0] fire;
  logic             mode_q, frst_q, pend_q, warn_q;
  logic             mode_clr;

  assign acc      = wr_en_i && ready_o;
  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));

  for (genvar g = 0; g < NPROT; g++) begin : g_prot
    frc_unlock #(.FIRST(FIRST_VAL[g])) u_unlock (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (acc),
      .hit_i (ctrl_hit),
      .bit_i (wdata_i[g]),
      .fire_o(fire[g])
    );
  end

  assign mode_clr = acc && ctrl_hit && !wdata_i[B_MODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      frst_q <= 1'b0;
      pend_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      frst_q <= fire[B_FRST];
      if (fire[B_MODE])  mode_q <= 1'b1;
      else if (mode_clr) mode_q <= 1'b0;
      if (op_start_i)                          pend_q <= 1'b1;
      else if (read_array_i || fire[B_FRST])   pend_q <= 1'b0;
      if (mode_q && mode_clr && pend_q)        warn_q <= 1'b1;
    end
  end

  frc_hold #(.CLK_KHZ(CLK_KHZ), .HOLD_US(HOLD_US)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_busy_i(erase_busy_i),
    .ready_o     (ready_o)
  );

  frc_clkchk #(
    .SRC_KHZ(SRC_KHZ), .LIM0_KHZ(LIM0_KHZ), .LIM1_KHZ(LIM1_KHZ), .DIV_W(DIV_W)
  ) u_clkchk (
    .active_i (mode_q),
    .wait_i   (wait_i),
    .clk_div_i(clk_div_i),
    .err_o    (cfg_err_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rdata_o[B_MODE] = mode_q;
    end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
      rdata_o[S_ACT]  = mode_q;
      rdata_o[S_ERR]  = cfg_err_o;
      rdata_o[S_WARN] = warn_q;
      rdata_o[S_RDY]  = ready_o;
    end
  end

  assign rw_active_o = mode_q;
  assign flash_rst_o = frst_q;
  assign warn_o      = warn_q;
  assign boot_addr_o = BOOT_ADDR;
endmodule

// File: rtl/frc_checker.sv
module frc_checker
  import frc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rw_active_o,
  input logic              flash_rst_o,
  input logic              cfg_err_o,
  input logic              warn_o,
  input logic              ready_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && ready_o && (addr_i == ADDR_W'(CTRL_ADDR));

  p_mode_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rw_active_o) |-> $past(ctrl_wr && wdata_i[B_MODE]));

  p_mode_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[B_MODE]) |=> !rw_active_o);

  p_frst_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rst_o |-> $past(ctrl_wr && !wdata_i[B_FRST]));

  p_hold_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(rw_active_o));

  p_cfg_err_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> rw_active_o);

  p_warn_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> warn_o);
endmodule

bind flash_rw_ctrl frc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rw_active_o(rw_active_o),
  .flash_rst_o(flash_rst_o),
  .cfg_err_o  (cfg_err_o),
  .warn_o     (warn_o),
  .ready_o    (ready_o)
);

// File: tb/flash_rw_ctrl_tb_top.sv
module flash_rw_ctrl_tb_top;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int DIV_W    = 2;
  localparam int CLK_KHZ  = 1000;
  localparam int HOLD_US  = 50;
  localparam int SRC_KHZ  = 20000;
  localparam int HOLD_CYC = CLK_KHZ * HOLD_US / 1000;
  localparam int NVEC     = 15;

  // {addr[1:0], data[7:0], exp_mode, exp_frst}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 8'h01, 1'b0, 1'b0},  // R1 lone 1
    {2'd0, 8'h00, 1'b0, 1'b0},
    {2'd0, 8'h01, 1'b1, 1'b0},  // R1 enter
    {2'd0, 8'h00, 1'b0, 1'b0},  // R2 clear
    {2'd1, 8'h00, 1'b0, 1'b0},  // R4 abort via STATUS
    {2'd0, 8'h01, 1'b0, 1'b0},  // R4
    {2'd0, 8'h00, 1'b0, 1'b0},
    {2'd0, 8'h01, 1'b1, 1'b0},
    {2'd0, 8'h03, 1'b1, 1'b0},
    {2'd0, 8'h01, 1'b1, 1'b1},  // R3 pulse
    {2'd0, 8'h03, 1'b1, 1'b0},
    {2'd1, 8'h00, 1'b1, 1'b0},  // R4 abort
    {2'd0, 8'h01, 1'b1, 1'b0},  // R4 no pulse
    {2'd0, 8'h02, 1'b0, 1'b0},
    {2'd0, 8'h01, 1'b1, 1'b1}   // R1+R3 same write
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              erase_busy_i = 1'b0;
  logic              op_start_i = 1'b0;
  logic              read_array_i = 1'b0;
  logic              wait_i = 1'b0;
  logic [DIV_W-1:0]  clk_div_i = '0;
  logic              rw_active_o, flash_rst_o, cfg_err_o, warn_o, ready_o;
  logic [23:0]       boot_addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_rw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .CLK_KHZ(CLK_KHZ), .HOLD_US(HOLD_US), .SRC_KHZ(SRC_KHZ)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .erase_busy_i(erase_busy_i),
    .op_start_i(op_start_i), .read_array_i(read_array_i), .wait_i(wait_i),
    .clk_div_i(clk_div_i), .rw_active_o(rw_active_o), .flash_rst_o(flash_rst_o),
    .cfg_err_o(cfg_err_o), .warn_o(warn_o), .ready_o(ready_o),
    .boot_addr_o(boot_addr_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_op(bit rd);
    @(negedge clk_i);
    if (rd) read_array_i = 1'b1; else op_start_i = 1'b1;
    @(negedge clk_i);
    read_array_i = 1'b0; op_start_i = 1'b0;
  endtask

  // returns cycles with ready_o low after release
  task automatic do_reset(bit erase, output int n);
    @(negedge clk_i);
    erase_busy_i = erase;
    @(negedge clk_i);
    rst_ni = 1'b0; erase_busy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    while (!ready_o && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset(1'b0, n);
    chk("R6 normal reset not-ready cycles", 32'(n), 32'd1);
    chk("R5 reset mode off", 32'(rw_active_o), 32'd0);
    chk("R7 boot address", 32'(boot_addr_o), 32'h07E000);
    addr_i = 2'd1; #1;
    chk("R5 STATUS after reset", 32'(rdata_o), 32'h08);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][11:10], VEC[i][9:2]);
      chk($sformatf("R1/R2 vec %0d mode", i), 32'(rw_active_o), 32'(VEC[i][1]));
      chk($sformatf("R3/R4 vec %0d frst", i), 32'(flash_rst_o), 32'(VEC[i][0]));
    end
    @(negedge clk_i);
    chk("R3 pulse one cycle", 32'(flash_rst_o), 32'd0);

    // mode is on here
    addr_i = 2'd0; #1;
    chk("R5 CTRL read", 32'(rdata_o), 32'h01);
    addr_i = 2'd1; #1;
    chk("R5 STATUS active", 32'(rdata_o[0]), 32'd1);

    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 4; d++) begin
        @(negedge clk_i);
        wait_i = w[0]; clk_div_i = d[1:0]; #1;
        chk($sformatf("R8 wait %0d div %0d", w, d), 32'(cfg_err_o),
            32'((SRC_KHZ >> d) > (w != 0 ? 10000 : 5000)));
      end
    end
    @(negedge clk_i); wait_i = 1'b0; clk_div_i = 2'd0; #1;
    addr_i = 2'd1; #1;
    chk("R8 STATUS err bit", 32'(rdata_o[1]), 32'd1);

    // R9 unsafe exit
    pulse_op(1'b0);
    wr(2'd0, 8'h00);
    chk("R8 err clear when mode off", 32'(cfg_err_o), 32'd0);
    chk("R9 warn set on unsafe exit", 32'(warn_o), 32'd1);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk("R9 warn sticky", 32'(warn_o), 32'd1);

    // R9 safe exit after read-array
    do_reset(1'b0, n);
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    pulse_op(1'b0); pulse_op(1'b1);
    wr(2'd0, 8'h00);
    chk("R9 no warn after read array", 32'(warn_o), 32'd0);

    // R9 safe exit after flash reset sequence
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    pulse_op(1'b0);
    wr(2'd0, 8'h03); wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk("R9 no warn after flash reset", 32'(warn_o), 32'd0);

    // R6 erase-cut reset
    do_reset(1'b1, n);
    chk("R6 erase reset hold cycles", 32'(n), 32'(HOLD_CYC + 1));
    chk("R7 boot address after hold", 32'(boot_addr_o), 32'h07E000);

    // R6 writes ignored during hold
    @(negedge clk_i); erase_busy_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b0; erase_busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    chk("R6 not ready during hold", 32'(ready_o), 32'd0);
    while (!ready_o) @(negedge clk_i);
    chk("R6 writes ignored during hold", 32'(rw_active_o), 32'd0);
    wr(2'd0, 8'h01);
    chk("R6 no arm left from hold", 32'(rw_active_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule